// File: doc/BRIEF.md
# Pixel Packer for Memory Write Bursts

The block takes a stream of 21-bit pixels, four per input beat, and packs them into 520-bit words for a memory write FIFO. A word is made of eight 65-bit lanes. Each data lane holds three pixels, a zero pad bit and a flag bit that is clear. Six beats fill one word, so a group of four pixels often runs across a lane boundary. The word goes to the FIFO once the sixth beat has been stored.

Each burst of data words starts with a header word. In a header word every lane has its flag set and carries the same routing record: the operation kind, the address, the burst length and the destination. A downstream reader looks only at the flag of lane 7 to tell headers from data. The input side uses a valid/ready handshake. The output side drives the push port of a FIFO through a write enable and watches the FIFO's full signal.

Top module: `pixel_packer`

## Requirements
- R1: In a data lane, bit 64 (the flag) is 0 and bit 63 is 0. The lane's first pixel sits at [62:42], its second at [41:21] and its third at [20:0].
- R2: Input pixel k of a beat is `pixIn[k*21 +: 21]`, and pixel 0 comes first in the stream. Stream pixel n of a word goes to lane n/3, slot n%3. Lane L occupies `wrData[(7-L)*65 +: 65]`, so lane 0 holds the most significant bits and lane 7 holds bits [64:0].
- R3: A data word is pushed only after six beats have been accepted. After the sixth beat, `inReady` is low until that word has been pushed. The next word then starts again at lane 0, slot 0.
- R4: In a header word, all eight lanes are identical and have bit 64 set to 1. The other fields are:
  - [63:62] is 2'b01 (write).
  - [61:34] is `cfgAddr`.
  - [33:29] is `cfgLen`.
  - [28:25] is `cfgDest`.
  - [24:0] is zero.
- R5: A header word is pushed before the first data word of each burst. A burst holds `cfgLen` data words; a value of 0 means 32.
- R6: While `full` is high, `wrEn` and `inReady` are both low. Under any pattern of backpressure, no pixel is lost or duplicated.
- R7: A synchronous reset discards any partly filled word. The first push after reset is a header, and the next data word holds only pixels accepted after the reset.
- R8: While a header waits to be pushed, `inReady` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Block can take a beat |
| pixIn | input | 84 | Four pixels, pixel 0 in the low bits |
| cfgAddr | input | 28 | Address placed in headers |
| cfgLen | input | 5 | Data words per burst (0 means 32) |
| cfgDest | input | 4 | Destination placed in headers |
| wrEn | output | 1 | Push strobe to the write FIFO |
| full | input | 1 | Write FIFO full |
| wrData | output | 520 | Word pushed to the FIFO |

## Verification
The hardest case to reach is backpressure that arrives at the moment a word completes or a header is due. If that case went wrong, a pixel could be overwritten or a word pushed twice. The stimulus drives `full` from a free-running pseudo-random pattern while beats stream in, so `full` rises and falls on every phase of the six-beat group and of the header step. Every pushed word is then compared with a word rebuilt from the pixel sequence that was sent. A reset in the middle of a word and a 32-word burst cover the remaining edges.

// File: rtl/packer_pkg.sv
package packer_pkg;
  localparam int PIX_W     = 21;
  localparam int SLOTS     = 3;
  localparam int LANES     = 8;
  localparam int BEAT_PIX  = 4;
  localparam int LANE_W    = 2 + SLOTS * PIX_W;
  localparam int WORD_W    = LANES * LANE_W;
  localparam int TOTAL_PIX = LANES * SLOTS;
  localparam int GROUPS    = TOTAL_PIX / BEAT_PIX;
  localparam int GRP_W     = $clog2(GROUPS);
  localparam int BEAT_W    = BEAT_PIX * PIX_W;
  localparam int ADDR_W    = 28;
  localparam int LEN_W     = 5;
  localparam int DEST_W    = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic             loadBeat;
    logic [GRP_W-1:0] grpIdx;
    logic             selHeader;
  } strobeT;

  // routing record carried by every lane of a header word
  typedef struct packed {
    logic              isCtrl;
    logic [1:0]        opKind;
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  burstLen;
    logic [DEST_W-1:0] dest;
    logic [2:0]        spare;
    logic [2:0]        srcLane;
    logic [7:0]        rowPos;
    logic [7:0]        colPos;
    logic [2:0]        fmt;
  } ctrlLaneT;

  typedef struct packed {
    logic                          isCtrl;
    logic                          pad;
    logic [0:SLOTS-1][PIX_W-1:0]   slots;
  } dataLaneT;
endpackage

// File: rtl/packer_ctrl.sv
module packer_ctrl
  import packer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             full,
  input  logic [LEN_W-1:0] cfgLen,
  output logic             inReady,
  output logic             wrEn,
  output strobeT           strobe
);
  typedef enum logic [0:0] {ST_HDR, ST_DATA} stateT;

  stateT             state;
  logic [GRP_W-1:0]  grpCnt;
  logic [LEN_W-1:0]  wordCnt;
  logic              wordFull;
  logic              accept;
  logic              lastWord;
  logic              lastGroup;
  logic [LEN_W-1:0]  lenMinusOne;

  assign lenMinusOne = cfgLen - LEN_W'(1);
  assign lastWord    = (wordCnt == lenMinusOne);
  assign lastGroup   = (grpCnt == GRP_W'(GROUPS - 1));

  always_comb begin
    inReady = (state == ST_DATA) && !wordFull && !full;
    wrEn    = !full && ((state == ST_HDR) || wordFull);
    accept  = inValid && inReady;
    strobe.loadBeat  = accept;
    strobe.grpIdx    = grpCnt;
    strobe.selHeader = (state == ST_HDR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_HDR;
      grpCnt   <= '0;
      wordCnt  <= '0;
      wordFull <= 1'b0;
    end else begin
      if (state == ST_HDR && !full) begin
        state   <= ST_DATA;
        wordCnt <= '0;
      end
      if (accept) begin
        if (lastGroup) begin
          grpCnt   <= '0;
          wordFull <= 1'b1;
        end else begin
          grpCnt <= grpCnt + GRP_W'(1);
        end
      end
      if (state == ST_DATA && wordFull && !full) begin
        wordFull <= 1'b0;
        if (lastWord) begin
          state   <= ST_HDR;
          wordCnt <= '0;
        end else begin
          wordCnt <= wordCnt + LEN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/packer_dp.sv
module packer_dp
  import packer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobeT            strobe,
  input  logic [BEAT_W-1:0] pixIn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic [DEST_W-1:0] cfgDest,
  output logic [WORD_W-1:0] wrData
);
  logic [PIX_W-1:0]  pixStore [TOTAL_PIX];
  logic [WORD_W-1:0] dataWord;
  logic [WORD_W-1:0] headerWord;
  ctrlLaneT          hdrLane;

  // one register per pixel slot; each group of four writes its own slots
  for (genvar s = 0; s < TOTAL_PIX; s++) begin : g_slot
    localparam int GRP = s / BEAT_PIX;
    localparam int POS = s % BEAT_PIX;
    always_ff @(posedge clk) begin
      if (rst) begin
        pixStore[s] <= '0;
      end else if (strobe.loadBeat && strobe.grpIdx == GRP_W'(GRP)) begin
        pixStore[s] <= pixIn[POS*PIX_W +: PIX_W];
      end
    end
  end

  // lane L sits at the top of the word for L = 0
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    dataLaneT lane;
    always_comb begin
      lane.isCtrl = 1'b0;
      lane.pad    = 1'b0;
      for (int k = 0; k < SLOTS; k++) begin
        lane.slots[k] = pixStore[l*SLOTS + k];
      end
    end
    assign dataWord[(LANES-1-l)*LANE_W +: LANE_W] = lane;
    assign headerWord[(LANES-1-l)*LANE_W +: LANE_W] = hdrLane;
  end

  always_comb begin
    hdrLane          = '0;
    hdrLane.isCtrl   = 1'b1;
    hdrLane.opKind   = 2'b01;
    hdrLane.addr     = cfgAddr;
    hdrLane.burstLen = cfgLen;
    hdrLane.dest     = cfgDest;
  end

  assign wrData = strobe.selHeader ? headerWord : dataWord;
endmodule

// File: rtl/pixel_packer.sv
module pixel_packer
  import packer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  output logic              inReady,
  input  logic [BEAT_W-1:0] pixIn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic [DEST_W-1:0] cfgDest,
  output logic              wrEn,
  input  logic              full,
  output logic [WORD_W-1:0] wrData
);
  strobeT strobe;

  packer_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .full    (full),
    .cfgLen  (cfgLen),
    .inReady (inReady),
    .wrEn    (wrEn),
    .strobe  (strobe)
  );

  packer_dp u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .pixIn   (pixIn),
    .cfgAddr (cfgAddr),
    .cfgLen  (cfgLen),
    .cfgDest (cfgDest),
    .wrData  (wrData)
  );
endmodule

// File: rtl/packer_checker.sv
module packer_checker
  import packer_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              inReady,
  input logic [LEN_W-1:0]  cfgLen,
  input logic              wrEn,
  input logic              full,
  input logic [WORD_W-1:0] wrData
);
  logic [LANES-1:0] flagVec;
  logic [LANES-1:0] padVec;
  logic             pushedAny;
  logic [5:0]       dataSince;
  logic [3:0]       beatsSince;
  logic [5:0]       burstWords;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      flagVec[l] = wrData[l*LANE_W + LANE_W - 1];
      padVec[l]  = wrData[l*LANE_W + LANE_W - 2];
    end
    burstWords = (cfgLen == '0) ? 6'd32 : {1'b0, cfgLen};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pushedAny  <= 1'b0;
      dataSince  <= '0;
      beatsSince <= '0;
    end else begin
      if (wrEn) pushedAny <= 1'b1;
      if (wrEn && wrData[LANE_W-1]) dataSince <= '0;
      else if (wrEn) dataSince <= dataSince + 6'd1;
      if (wrEn && !wrData[LANE_W-1]) beatsSince <= '0;
      else if (inValid && inReady) beatsSince <= beatsSince + 4'd1;
    end
  end

  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst)
    full |-> !wrEn); // R6
  AST_NO_READY_FULL: assert property (@(posedge clk) disable iff (rst)
    full |-> !inReady); // R6
  AST_DATA_PAD: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !wrData[LANE_W-1]) |-> (flagVec == '0 && padVec == '0)); // R1
  AST_HDR_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrData[LANE_W-1]) |-> (&flagVec && wrData[LANE_W-2 -: 2] == 2'b01)); // R4
  AST_FIRST_IS_HDR: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !pushedAny) |-> wrData[LANE_W-1]); // R7
  AST_BURST_COUNT: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrData[LANE_W-1] && pushedAny) |-> (dataSince == burstWords)); // R5
  AST_SIX_BEATS: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !wrData[LANE_W-1]) |-> (beatsSince == 4'(GROUPS))); // R3
  AST_WAIT_NO_READY: assert property (@(posedge clk) disable iff (rst)
    (beatsSince == 4'(GROUPS)) |-> !inReady); // R3
endmodule

bind pixel_packer packer_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .inReady (inReady),
  .cfgLen  (cfgLen),
  .wrEn    (wrEn),
  .full    (full),
  .wrData  (wrData)
);

// File: tb/pixel_packer_bench.sv
module pixel_packer_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [83:0]  pixIn = '0;
  logic [27:0]  cfgAddr = '0;
  logic [4:0]   cfgLen = 5'd2;
  logic [3:0]   cfgDest = '0;
  logic         wrEn;
  logic         full;
  logic [519:0] wrData;

  int errors = 0;
  int checks = 0;
  int capCnt = 0;
  int violCnt = 0;
  int fullSeen = 0;
  bit fullMode = 1'b0;
  logic [7:0] lfsr = 8'hA5;
  logic [519:0] cap [0:47];

  always #10 clk = ~clk;

  pixel_packer u_pixel_packer (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .pixIn(pixIn),
    .cfgAddr(cfgAddr), .cfgLen(cfgLen), .cfgDest(cfgDest),
    .wrEn(wrEn), .full(full), .wrData(wrData)
  );

  // backpressure source, changes just after each rising edge
  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  end
  assign full = fullMode & lfsr[0];

  // monitor samples at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (wrEn && capCnt < 48) begin
        cap[capCnt] = wrData;
        capCnt = capCnt + 1;
      end
      if (full) begin
        fullSeen = fullSeen + 1;
        if (wrEn || inReady) violCnt = violCnt + 1;
      end
    end
  end

  function automatic logic [20:0] pv(int n);
    return 21'((n * 40503 + 11) & 32'h1FFFFF);
  endfunction

  function automatic logic [519:0] expData(int startBeat);
    logic [519:0] w = '0;
    for (int n = 0; n < 24; n++) begin
      int lane = n / 3;
      int slot = n % 3;
      w[(7-lane)*65 + (2-slot)*21 +: 21] = pv(startBeat*4 + n);
    end
    return w;
  endfunction

  function automatic logic [519:0] expHdr(logic [27:0] a, logic [4:0] l, logic [3:0] d);
    logic [64:0] ln = {1'b1, 2'b01, a, l, d, 25'd0};
    return {8{ln}};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [519:0] act, logic [519:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(posedge clk); #1;
    rst = 1'b1; inValid = 1'b0;
    repeat (3) @(posedge clk);
    #1; rst = 1'b0;
    capCnt = 0; violCnt = 0; fullSeen = 0;
  endtask

  task automatic sendBeat(int b);
    for (int k = 0; k < 4; k++) pixIn[k*21 +: 21] = pv(b*4 + k);
    inValid = 1'b1;
    forever begin
      @(negedge clk);
      if (inReady) begin
        @(posedge clk); #1;
        break;
      end
      @(posedge clk); #1;
    end
    inValid = 1'b0;
  endtask

  task automatic waitPushes(int n);
    for (int i = 0; i < 3000 && capCnt < n; i++) @(posedge clk);
    #1;
  endtask

  // R7 R8: state right after reset
  task automatic testReset();
    cfgAddr = 28'h1234567; cfgLen = 5'd2; cfgDest = 4'h9;
    doReset();
    @(negedge clk);
    chk(inReady == 1'b0, "R8", "inReady with header due", {519'd0, inReady}, 520'd0);
    chk(wrEn == 1'b1, "R7", "header push after reset", {519'd0, wrEn}, 520'd1);
    chk(wrData == expHdr(28'h1234567, 5'd2, 4'h9), "R4", "header content", wrData,
        expHdr(28'h1234567, 5'd2, 4'h9));
  endtask

  // R1 R2 R4 R5: two-word burst
  task automatic testBurst();
    cfgAddr = 28'hABCDEF0; cfgLen = 5'd2; cfgDest = 4'h3;
    doReset();
    for (int b = 0; b < 12; b++) sendBeat(b);
    waitPushes(4);
    chk(cap[0] == expHdr(28'hABCDEF0, 5'd2, 4'h3), "R4", "burst header", cap[0],
        expHdr(28'hABCDEF0, 5'd2, 4'h3));
    chk(cap[1] == expData(0), "R2", "first data word", cap[1], expData(0));
    chk(cap[1][64:63] == 2'b00, "R1", "lane 7 flag and pad", 520'(cap[1][64:63]), 520'd0);
    chk(cap[2] == expData(6), "R1", "second data word", cap[2], expData(6));
    chk(cap[3] == expHdr(28'hABCDEF0, 5'd2, 4'h3), "R5", "next burst header", cap[3],
        expHdr(28'hABCDEF0, 5'd2, 4'h3));
  endtask

  // R3: word waits, ready drops, then push
  task automatic testWait();
    cfgLen = 5'd4;
    doReset();
    for (int b = 0; b < 6; b++) sendBeat(20 + b);
    @(negedge clk);
    chk(inReady == 1'b0, "R3", "ready while word waits", {519'd0, inReady}, 520'd0);
    chk(wrEn == 1'b1 && wrData == expData(20), "R3", "push after sixth beat", wrData, expData(20));
    @(posedge clk); #1;
    @(negedge clk);
    chk(inReady == 1'b1, "R3", "ready after push", {519'd0, inReady}, 520'd1);
  endtask

  // R6: random backpressure
  task automatic testBackpressure();
    cfgAddr = 28'h0F0F0F0; cfgLen = 5'd3; cfgDest = 4'h6;
    doReset();
    fullMode = 1'b1;
    for (int b = 0; b < 18; b++) sendBeat(40 + b);
    waitPushes(5);
    fullMode = 1'b0;
    chk(violCnt == 0 && fullSeen > 0, "R6", "outputs low while full", 520'(violCnt), 520'd0);
    chk(cap[0] == expHdr(28'h0F0F0F0, 5'd3, 4'h6), "R6", "header under backpressure", cap[0],
        expHdr(28'h0F0F0F0, 5'd3, 4'h6));
    for (int w = 0; w < 3; w++)
      chk(cap[1+w] == expData(40 + 6*w), "R6", "data under backpressure", cap[1+w], expData(40 + 6*w));
    chk(capCnt == 5 && cap[4][519], "R5", "header after three words", 520'(capCnt), 520'd5);
  endtask

  // R5: length 0 means 32 words
  task automatic testLongBurst();
    cfgAddr = 28'h0000100; cfgLen = 5'd0; cfgDest = 4'h1;
    doReset();
    for (int b = 0; b < 192; b++) sendBeat(b);
    waitPushes(34);
    chk(cap[32] == expData(186), "R5", "word 32 of burst", cap[32], expData(186));
    chk(cap[33] == expHdr(28'h0000100, 5'd0, 4'h1), "R5", "header after 32 words", cap[33],
        expHdr(28'h0000100, 5'd0, 4'h1));
  endtask

  // R7: reset mid-word discards partial pixels
  task automatic testMidReset();
    cfgAddr = 28'h2222222; cfgLen = 5'd2; cfgDest = 4'h2;
    doReset();
    for (int b = 0; b < 3; b++) sendBeat(100 + b);
    doReset();
    for (int b = 0; b < 6; b++) sendBeat(200 + b);
    waitPushes(2);
    chk(cap[0][519] == 1'b1 && cap[0][64] == 1'b1, "R7", "first push is header", cap[0],
        expHdr(28'h2222222, 5'd2, 4'h2));
    chk(cap[1] == expData(200), "R7", "word after reset", cap[1], expData(200));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    testReset();
    testBurst();
    testWait();
    testBackpressure();
    testLongBurst();
    testMidReset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule